// File: doc/BRIEF.md
# SGMII Receive Elastic Buffer

This block carries decoded 8B/10B characters from the clock recovered off a serial link into the local fabric clock. Both clocks run at a nominal 125 MHz and may differ by up to 200 ppm. One character enters on every write clock and one leaves on every read clock. A character is 9 bits wide: bit 8 is the control flag and bits 7:0 carry the byte. Storage holds 64 characters, and reading starts at the half-full point. That gives 31 entries of headroom on each side, enough to carry a 1522-byte frame sent at 10 Mb/s, where every byte is repeated 100 times and the frame lasts 152200 cycles.

Between frames the block pulls its occupancy back toward the midpoint. If the buffer is too full, the write side drops a complete idle ordered set (K28.5 then D16.2) instead of storing it. If the buffer is too empty, the read side plays the last idle ordered set a second time without moving its pointer. A frame runs from its start delimiter to its end delimiter, and no character is added or removed inside it. Pointers cross between the domains in Gray code through two-flop synchronisers. The fill level and the sticky overflow and underflow flags come from the read domain. To clear the flags and re-centre the pointers, assert both synchronous resets together.

Write FSM: `W_GAP` (between frames) goes to `W_FRAME` when a start delimiter is stored, or to `W_SKIP` when an idle set is dropped. `W_SKIP` (discards the D16.2 half of the dropped set) always returns to `W_GAP`. `W_FRAME` returns to `W_GAP` when an end delimiter is stored. Read FSM: `R_PRIME` (no output) goes to `R_GAP` once the fill reaches half. `R_GAP` goes to `R_FRAME` on reading a start delimiter, or to `R_REP` when it begins a repeat by emitting K28.5. `R_REP` emits D16.2 and returns to `R_GAP`. `R_FRAME` returns to `R_GAP` on reading an end delimiter.

Top module: `sgmii_rx_elastic`

## Requirements
- R1: While both resets are held, rd_valid, ovf_flag and unf_flag are 0 and fill_level is 0. After release, output starts only once occupancy reaches DEPTH/2 (32), so the fill at the first valid character lies between 28 and 40.
- R2: With equal clocks, every frame comes out in order and unchanged, including the shortest frame of one data byte. Encodings: bit 8 is the control flag; the start delimiter is 0x1FB, the end delimiter is 0x1FD, and the idle set is 0x1BC followed by 0x050.
- R3: ovf_flag is set when the read-domain fill reaches DEPTH-1 (63). It stays 0 when the fill stays below that.
- R4: unf_flag is set when the fill falls to 1 or less after output has started. The read pointer never advances while the fill is 0. unf_flag stays 0 while the fill stays above 1.
- R5: When the writer is faster, idle sets are deleted between frames. The fill between frames then stays at or below MID+HYST+8 (44), including after a frame has pushed it higher.
- R6: When the writer is slower, idle sets are repeated between frames, so the fill between frames stays at or above MID-HYST-8 (20).
- R7: Ordered sets are never split. Outside a frame, every output 0x1BC is followed directly by 0x050.
- R8: No character is inserted or deleted inside a frame. Under clock skew the frame still arrives intact while the fill moves beyond the hysteresis band: to at least 41 for a fast writer, or to at most 24 for a slow writer.
- R9: Both flags stay set until the resets are asserted, and the resets clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered link clock |
| wr_srst | input | 1 | Synchronous reset, write domain |
| wr_char | input | 9 | Incoming character {ctrl, byte}, one per wr_clk |
| rd_clk | input | 1 | Local fabric clock |
| rd_srst | input | 1 | Synchronous reset, read domain |
| rd_char | output | 9 | Outgoing character {ctrl, byte} |
| rd_valid | output | 1 | rd_char holds a character this cycle |
| fill_level | output | ADDR_W+1 | Occupancy as seen in the read domain |
| ovf_flag | output | 1 | Sticky overflow |
| unf_flag | output | 1 | Sticky underflow |

## Verification
The bench builds the block with its defaults: ADDR_W = 6 (64 entries) and HYST = 4. It swings the writer's period by about 5 % either side of the reader's, far beyond 200 ppm. At that skew a few hundred frame characters move the fill past the hysteresis band, and a 1500-character frame drives it to 63 or to 1. Re-centring, the intact-frame rule and both sticky flags can therefore all be reached within a few thousand cycles.

// File: rtl/ebuf_pkg.sv
`timescale 1ns/1ps
package ebuf_pkg;
    localparam int CHAR_W = 9;
    typedef logic [CHAR_W-1:0] char_t;

    localparam char_t K_COMMA = 9'h1BC;
    localparam char_t D_IDLE2 = 9'h050;
    localparam char_t K_SOF   = 9'h1FB;
    localparam char_t K_EOF   = 9'h1FD;

    typedef enum logic [1:0] {W_GAP, W_FRAME, W_SKIP} wr_state_e;
    typedef enum logic [1:0] {R_PRIME, R_GAP, R_FRAME, R_REP} rd_state_e;
endpackage

// File: rtl/ebuf_gray_sync.sv
`timescale 1ns/1ps
module ebuf_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         srst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (srst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/ebuf_ram.sv
`timescale 1ns/1ps
module ebuf_ram #(
    parameter int ADDR_W = 6,
    parameter int W      = 9
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [W-1:0]      wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [W-1:0]      rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ebuf_wr_side.sv
`timescale 1ns/1ps
module ebuf_wr_side
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int HYST   = 4
) (
    input  logic              clk,
    input  logic              srst,
    input  char_t             in_char,
    input  logic [ADDR_W:0]   rd_gray_sync,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output char_t             wdata,
    output logic [ADDR_W:0]   wr_gray
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int MID   = 1 << (ADDR_W - 1);
    localparam logic [PTR_W-1:0] HIGH_MARK = PTR_W'(MID + HYST);

    wr_state_e        state, nstate;
    char_t            held;
    logic [PTR_W-1:0] wptr, wptr_nxt, rd_bin, wfill;
    logic             drop_now;

    always_comb begin
        for (int i = 0; i < PTR_W; i++) rd_bin[i] = ^(rd_gray_sync >> i);
    end

    assign wfill    = wptr - rd_bin;
    assign drop_now = (state == W_GAP) && (held == K_COMMA) &&
                      (in_char == D_IDLE2) && (wfill > HIGH_MARK);

    always_comb begin
        nstate = state;
        unique case (state)
            W_GAP:   if (drop_now) nstate = W_SKIP;
                     else if (held == K_SOF) nstate = W_FRAME;
            W_FRAME: if (held == K_EOF) nstate = W_GAP;
            W_SKIP:  nstate = W_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) state <= W_GAP;
        else      state <= nstate;
    end

    assign we       = !(drop_now || state == W_SKIP);
    assign waddr    = wptr[ADDR_W-1:0];
    assign wdata    = held;
    assign wptr_nxt = wptr + PTR_W'(we);

    always_ff @(posedge clk) begin
        if (srst) begin
            held    <= D_IDLE2;
            wptr    <= '0;
            wr_gray <= '0;
        end else begin
            held    <= in_char;
            wptr    <= wptr_nxt;
            wr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
        end
    end

    // A dropped set is only ever entered from the between-frames state (R8)
    assert_skip_from_gap_R8: assert property (@(posedge clk) disable iff (srst)
        (state == W_SKIP) |-> ($past(state) == W_GAP));
    // Both halves of a dropped set go, and nothing more (R7)
    assert_skip_once_R7: assert property (@(posedge clk) disable iff (srst)
        (state == W_SKIP) |=> (state == W_GAP));
    // Pointer crossing relies on one Gray bit changing per cycle (R2)
    assert_wgray_step_R2: assert property (@(posedge clk) disable iff (srst)
        $onehot0(wr_gray ^ $past(wr_gray)));
endmodule

// File: rtl/ebuf_rd_side.sv
`timescale 1ns/1ps
module ebuf_rd_side
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int HYST   = 4
) (
    input  logic              clk,
    input  logic              srst,
    input  char_t             mem_char,
    input  logic [ADDR_W:0]   wr_gray_sync,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rd_gray,
    output char_t             out_char,
    output logic              out_valid,
    output logic [ADDR_W:0]   fill,
    output logic              ovf,
    output logic              unf
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MID   = DEPTH / 2;
    localparam logic [PTR_W-1:0] MID_MARK  = PTR_W'(MID);
    localparam logic [PTR_W-1:0] LOW_MARK  = PTR_W'(MID - HYST);
    localparam logic [PTR_W-1:0] FULL_MARK = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] ONE       = PTR_W'(1);

    rd_state_e        state, nstate;
    logic [PTR_W-1:0] rptr, rptr_nxt, wr_bin;
    char_t            prev_char;
    logic             running, advance, rep_start;

    always_comb begin
        for (int i = 0; i < PTR_W; i++) wr_bin[i] = ^(wr_gray_sync >> i);
    end

    assign fill      = wr_bin - rptr;
    assign running   = (state == R_GAP) || (state == R_FRAME);
    assign rep_start = (state == R_GAP) && (out_char == D_IDLE2) &&
                       (prev_char == K_COMMA) && (fill < LOW_MARK);
    assign advance   = running && !rep_start && (fill != '0);
    assign rptr_nxt  = rptr + PTR_W'(advance);
    assign raddr     = rptr[ADDR_W-1:0];

    always_comb begin
        nstate = state;
        unique case (state)
            R_PRIME: if (fill >= MID_MARK) nstate = R_GAP;
            R_GAP:   if (rep_start) nstate = R_REP;
                     else if (advance && mem_char == K_SOF) nstate = R_FRAME;
            R_FRAME: if (advance && mem_char == K_EOF) nstate = R_GAP;
            R_REP:   nstate = R_GAP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (srst) state <= R_PRIME;
        else      state <= nstate;
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            rptr      <= '0;
            rd_gray   <= '0;
            out_char  <= D_IDLE2;
            prev_char <= D_IDLE2;
            out_valid <= 1'b0;
            ovf       <= 1'b0;
            unf       <= 1'b0;
        end else begin
            rptr    <= rptr_nxt;
            rd_gray <= rptr_nxt ^ (rptr_nxt >> 1);
            if (advance) begin
                prev_char <= out_char;
                out_char  <= mem_char;
                out_valid <= 1'b1;
            end else if (rep_start) begin
                prev_char <= out_char;
                out_char  <= K_COMMA;
                out_valid <= 1'b1;
            end else if (state == R_REP) begin
                prev_char <= out_char;
                out_char  <= D_IDLE2;
                out_valid <= 1'b1;
            end else begin
                out_valid <= 1'b0;
            end
            ovf <= ovf | (fill >= FULL_MARK);
            unf <= unf | ((state != R_PRIME) && (fill <= ONE));
        end
    end

    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (srst)
        ovf |=> ovf);
    assert_unf_sticky_R9: assert property (@(posedge clk) disable iff (srst)
        unf |=> unf);
    assert_no_read_empty_R4: assert property (@(posedge clk) disable iff (srst)
        (fill == '0) |=> $stable(rptr));
    assert_rep_from_gap_R8: assert property (@(posedge clk) disable iff (srst)
        (state == R_REP) |-> ($past(state) == R_GAP));
    assert_rep_completes_R7: assert property (@(posedge clk) disable iff (srst)
        (state == R_REP) |=> (out_char == D_IDLE2 && out_valid));
    assert_rgray_step_R2: assert property (@(posedge clk) disable iff (srst)
        $onehot0(rd_gray ^ $past(rd_gray)));
endmodule

// File: rtl/sgmii_rx_elastic.sv
`timescale 1ns/1ps
module sgmii_rx_elastic
    import ebuf_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int HYST   = 4
) (
    input  logic            wr_clk,
    input  logic            wr_srst,
    input  logic [8:0]      wr_char,
    input  logic            rd_clk,
    input  logic            rd_srst,
    output logic [8:0]      rd_char,
    output logic            rd_valid,
    output logic [ADDR_W:0] fill_level,
    output logic            ovf_flag,
    output logic            unf_flag
);
    localparam int PTR_W = ADDR_W + 1;

    logic              we;
    logic [ADDR_W-1:0] waddr, raddr;
    char_t             wdata, mem_char;
    logic [PTR_W-1:0]  wr_gray, rd_gray, wr_gray_rs, rd_gray_ws;

    ebuf_wr_side #(.ADDR_W(ADDR_W), .HYST(HYST)) u_wr (
        .clk(wr_clk), .srst(wr_srst), .in_char(wr_char),
        .rd_gray_sync(rd_gray_ws), .we(we), .waddr(waddr),
        .wdata(wdata), .wr_gray(wr_gray)
    );

    ebuf_ram #(.ADDR_W(ADDR_W), .W(CHAR_W)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wdata),
        .raddr(raddr), .rdata(mem_char)
    );

    ebuf_gray_sync #(.W(PTR_W)) u_sync_w2r (
        .clk(rd_clk), .srst(rd_srst), .d(wr_gray), .q(wr_gray_rs)
    );

    ebuf_gray_sync #(.W(PTR_W)) u_sync_r2w (
        .clk(wr_clk), .srst(wr_srst), .d(rd_gray), .q(rd_gray_ws)
    );

    ebuf_rd_side #(.ADDR_W(ADDR_W), .HYST(HYST)) u_rd (
        .clk(rd_clk), .srst(rd_srst), .mem_char(mem_char),
        .wr_gray_sync(wr_gray_rs), .raddr(raddr), .rd_gray(rd_gray),
        .out_char(rd_char), .out_valid(rd_valid), .fill(fill_level),
        .ovf(ovf_flag), .unf(unf_flag)
    );
endmodule

// File: tb/test_sgmii_rx_elastic.sv
`timescale 1ns/1ps
module test_sgmii_rx_elastic;
    localparam logic [8:0] C_K   = 9'h1BC;
    localparam logic [8:0] C_D   = 9'h050;
    localparam logic [8:0] C_SOF = 9'h1FB;
    localparam logic [8:0] C_EOF = 9'h1FD;

    logic       wr_clk = 1'b0, rd_clk = 1'b0;
    logic       wr_srst = 1'b1, rd_srst = 1'b1;
    logic [8:0] wr_char = C_K;
    logic [8:0] rd_char;
    logic       rd_valid, ovf_flag, unf_flag;
    logic [6:0] fill_level;

    real wr_half = 5.0;
    real rd_half = 5.0;

    int n_tests = 0, n_fail = 0;

    logic [8:0] txq[$];
    logic [8:0] exp_q[$];
    logic [8:0] cap_q[$];
    logic [8:0] got_q[$];
    int  frames_done = 0;
    int  gmax, gmin, fmax, fmin, splits;
    logic [8:0] prev_out = 9'h000;
    bit  in_frame = 1'b0;

    sgmii_rx_elastic i_sgmii_rx_elastic (
        .wr_clk(wr_clk), .wr_srst(wr_srst), .wr_char(wr_char),
        .rd_clk(rd_clk), .rd_srst(rd_srst), .rd_char(rd_char),
        .rd_valid(rd_valid), .fill_level(fill_level),
        .ovf_flag(ovf_flag), .unf_flag(unf_flag)
    );

    initial begin
        #1.3;
        forever #(wr_half) wr_clk = ~wr_clk;
    end
    initial forever #(rd_half) rd_clk = ~rd_clk;

    // link driver: idle sets kept whole, queued characters inserted at set boundaries
    initial begin
        bit ph = 1'b0;
        forever begin
            @(negedge wr_clk);
            if (ph) begin
                wr_char = C_D;
                ph = 1'b0;
            end else if (txq.size() > 0) begin
                wr_char = txq.pop_front();
            end else begin
                wr_char = C_K;
                ph = 1'b1;
            end
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge rd_clk);
            if (rd_srst) begin
                in_frame = 1'b0;
                prev_out = 9'h000;
            end else if (rd_valid) begin
                if (in_frame) begin
                    cap_q.push_back(rd_char);
                    if (fill_level > fmax) fmax = fill_level;
                    if (fill_level < fmin) fmin = fill_level;
                    if (rd_char == C_EOF) begin
                        in_frame = 1'b0;
                        got_q = cap_q;
                        frames_done++;
                    end
                end else begin
                    if (prev_out == C_K && rd_char != C_D) splits++;
                    if (fill_level > gmax) gmax = fill_level;
                    if (fill_level < gmin) gmin = fill_level;
                    if (rd_char == C_SOF) begin
                        in_frame = 1'b1;
                        cap_q.delete();
                        cap_q.push_back(rd_char);
                    end
                end
                prev_out = rd_char;
            end
        end
    end

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge rd_clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        gmax = 0; gmin = 999; fmax = 0; fmin = 999; splits = 0;
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge rd_clk);
    endtask

    task automatic send_frame(input int len, input int seed);
        exp_q.delete();
        exp_q.push_back(C_SOF);
        for (int i = 0; i < len; i++) exp_q.push_back({1'b0, 8'((i * 7 + seed) & 255)});
        exp_q.push_back(C_EOF);
        foreach (exp_q[i]) txq.push_back(exp_q[i]);
    endtask

    task automatic wait_tx_drained();
        int t = 0;
        while (txq.size() > 0 && t < 20000) begin
            @(negedge rd_clk);
            t++;
        end
    endtask

    task automatic wait_frame_check(input string req);
        int start = frames_done;
        int t = 0;
        int bad = 0;
        while (frames_done == start && t < 20000) begin
            @(negedge rd_clk);
            t++;
        end
        chk(frames_done != start, req, "frame arrived", frames_done - start, 1);
        if (got_q.size() != exp_q.size()) bad = 1;
        else foreach (exp_q[i]) if (got_q[i] !== exp_q[i]) bad++;
        chk(bad == 0, req, "frame length with mismatches", got_q.size() + 1000 * bad, exp_q.size());
    endtask

    // R1: reset state and half-full start
    task automatic t_reset();
        int t = 0;
        wr_srst = 1'b1;
        rd_srst = 1'b1;
        cycles(8);
        chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
        chk(ovf_flag == 1'b0 && unf_flag == 1'b0, "R1", "flags in reset",
            {ovf_flag, unf_flag}, 0);
        chk(fill_level == 0, "R1", "fill in reset", fill_level, 0);
        wr_srst = 1'b0;
        rd_srst = 1'b0;
        while (!rd_valid && t < 2000) begin
            @(negedge rd_clk);
            t++;
        end
        chk(rd_valid == 1'b1, "R1", "output started", rd_valid, 1);
        chk(fill_level >= 28 && fill_level <= 40, "R1", "fill at first valid", fill_level, 32);
    endtask

    // R2, R7: equal clocks, plain and shortest frames
    task automatic t_equal();
        wr_half = 5.0;
        cycles(200);
        clear_stats();
        send_frame(60, 3);
        wait_frame_check("R2");
        send_frame(1, 9);
        wait_frame_check("R2");
        cycles(100);
        chk(splits == 0, "R7", "split idle sets", splits, 0);
    endtask

    // R5, R7, R8, R3: writer 5 % faster
    task automatic t_fast();
        wr_half = 4.75;
        cycles(1500);
        clear_stats();
        cycles(2500);
        chk(gmax <= 44, "R5", "max gap fill", gmax, 44);
        chk(splits == 0, "R7", "split idle sets", splits, 0);
        chk(ovf_flag == 1'b0, "R3", "no false overflow", ovf_flag, 0);
        clear_stats();
        send_frame(300, 5);
        wait_frame_check("R8");
        chk(fmax >= 41, "R8", "in-frame fill rose", fmax, 41);
        cycles(1500);
        clear_stats();
        cycles(1000);
        chk(gmax <= 44, "R5", "fill recentred after frame", gmax, 44);
    endtask

    // R6, R7, R8, R4: writer 5 % slower
    task automatic t_slow();
        wr_half = 5.25;
        cycles(1500);
        clear_stats();
        cycles(2500);
        chk(gmin >= 20, "R6", "min gap fill", gmin, 20);
        chk(splits == 0, "R7", "split idle sets", splits, 0);
        chk(unf_flag == 1'b0, "R4", "no false underflow", unf_flag, 0);
        clear_stats();
        send_frame(300, 11);
        wait_frame_check("R8");
        chk(fmin <= 24, "R8", "in-frame fill fell", fmin, 24);
        chk(unf_flag == 1'b0, "R4", "no underflow above 1", unf_flag, 0);
    endtask

    // R3, R9: overflow and its clearing
    task automatic t_overflow();
        wr_half = 4.75;
        cycles(500);
        send_frame(1500, 1);
        wait_tx_drained();
        cycles(300);
        chk(ovf_flag == 1'b1, "R3", "overflow set", ovf_flag, 1);
        wr_half = 5.0;
        cycles(1000);
        chk(ovf_flag == 1'b1, "R9", "overflow sticky", ovf_flag, 1);
        t_reset();
        chk(ovf_flag == 1'b0, "R9", "overflow cleared", ovf_flag, 0);
    endtask

    // R4, R9: underflow and its clearing
    task automatic t_underflow();
        wr_half = 5.25;
        cycles(500);
        send_frame(1500, 2);
        wait_tx_drained();
        cycles(300);
        chk(unf_flag == 1'b1, "R4", "underflow set", unf_flag, 1);
        chk(ovf_flag == 1'b0, "R3", "no overflow on drain", ovf_flag, 0);
        wr_half = 5.0;
        cycles(1000);
        chk(unf_flag == 1'b1, "R9", "underflow sticky", unf_flag, 1);
        t_reset();
        chk(unf_flag == 1'b0, "R9", "underflow cleared", unf_flag, 0);
    endtask

    initial begin
        clear_stats();
        t_reset();
        t_equal();
        t_fast();
        t_slow();
        t_overflow();
        t_underflow();
        summary();
        $finish;
    end
endmodule